// File: doc/BRIEF.md
# Serial Auto-Baud Link Handshake

After reset this block watches a serial receive line and learns the host's bit rate from the characters that arrive on it. The host keeps sending bytes of value zero. In an 8N1 frame such a byte drives the line low for the start bit and all eight data bits. The block counts how many clock cycles that low stretch lasts. It divides the count by nine and rounds to the nearest integer, and the result is the number of clocks per bit. That divisor then times a small transmitter and a small receiver inside the block.

With the divisor known, the block sends one zero byte back to the host as its acknowledge. It then listens for a single confirmation byte of value 0x55. A clean confirmation puts the link into the locked state for good. A wrong byte, a missing stop bit, a low period that is too long to count, or a divisor that is too small for midpoint sampling puts the block into the failed state. It stays failed until the next reset, which is the only way to start a new measurement.

A boot loader places this block in front of its command channel. Once `locked` is high it reads `divisor` to program its own serial engine.

Top module: `baud_lock_handshake`

## Requirements
- R1: While reset is applied, and after it, until something else happens: `txd` is 1, `divisor` is 0, `locked` is 0 and `failed` is 0. Reset is synchronous and active high.
- R2: The block ignores `rxd` for the first SETTLE_CYC (default 100) cycles after reset is released. A measurement begins only when `rxd` goes from high to low after that window. A line that is already low when the window ends is skipped until it has returned high.
- R3: Let L be the number of clock edges at which `rxd` is sampled low during the measured pulse. `divisor` becomes floor((L+4)/9), which is L/9 rounded to the nearest integer. The new value is visible after the third clock edge that follows the first edge that samples `rxd` high again. This latency includes a two-stage input synchronizer.
- R4: If the rounded divisor is below 2, `failed` rises in the same cycle that the divisor appears. No acknowledge is sent.
- R5: The low-period counter saturates at 2^CNT_W−1. A pulse of exactly that length is measured normally. A longer pulse raises `failed` after clock edge c0+2^CNT_W+2, where c0 is the first edge that samples `rxd` low. In that case `divisor` stays 0.
- R6: After a good measurement the block sends the acknowledge byte 0x00 as an 8N1 frame: start bit low, data bits LSB first, stop bit high. `txd` is therefore low for exactly 9×divisor cycles, starting one edge after the divisor appears. It is then high for a stop bit of divisor cycles. `txd` stays high at all other times.
- R7: The receiver is armed once the acknowledge stop bit has ended. It detects a start bit when the synchronized line is low. It samples the start bit divisor>>1 cycles later and each following bit every divisor cycles. A byte 0x55 with a high stop bit raises `locked`, visible after edge q0+(divisor>>1)+9×divisor+3, where q0 is the first edge that samples the start bit low.
- R8: A received data value other than 0x55 raises `failed` at the time given in R7.
- R9: A stop bit sampled low raises `failed` at the time given in R7, even when the data is 0x55.
- R10: `locked` and `failed` never rise together and, once set, hold until reset. After either one is set, further activity on `rxd` leaves `txd`, `divisor`, `locked` and `failed` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Serial line from the host, idle high |
| txd | output | 1 | Serial line to the host, idle high |
| divisor | output | CNT_W | Learned clock cycles per bit |
| locked | output | 1 | Handshake completed with a valid confirmation |
| failed | output | 1 | Measurement or handshake error, held until reset |

## Verification
The embedded properties assume two things about `rxd`. First, every bit the host sends is at least two clocks long, so the receiver never runs with a divisor that leaves no half-bit. Second, the host does not start its confirmation byte before the acknowledge stop bit has ended. The stimulus respects both. The host bytes are driven at exactly the learned divisor and always on clock-aligned boundaries. Each confirmation byte is sent only after an idle gap longer than the acknowledge frame plus twenty cycles. Only the sticky-status and quiet-transmitter properties remain meaningful for a line that misbehaves. The bench exercises those with out-of-window pulses, wrong bytes and a bad stop bit.

// File: rtl/abl_pkg.sv
package abl_pkg;

    // A zero byte in 8N1 keeps the line low for start + 8 data bits
    localparam int unsigned LOW_BITS    = 9;
    localparam int unsigned FRAME_BITS  = 10;
    localparam int unsigned MIN_DIV     = 2;
    localparam logic [7:0]  ACK_CODE    = 8'h00;
    localparam logic [7:0]  CONFIRM_CODE = 8'h55;

    typedef enum logic [2:0] {
        PH_WAIT,
        PH_MEASURE,
        PH_ACK,
        PH_LISTEN,
        PH_LOCKED,
        PH_FAILED
    } phase_t;

    typedef enum logic [1:0] {
        MT_SEEK_HIGH,
        MT_SEEK_LOW,
        MT_COUNT,
        MT_HOLD
    } meter_st_t;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_st_t;

    typedef struct packed {
        logic [7:0] data;
        logic       frame_ok;
    } rx_word_t;

    // Rounded division of the low-period length by the bit count
    function automatic int unsigned div_nearest(input int unsigned cycles);
        return (cycles + LOW_BITS / 2) / LOW_BITS;
    endfunction

endpackage

// File: rtl/abl_sync.sv
module abl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/abl_low_meter.sv
module abl_low_meter import abl_pkg::*; #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             rx_s,
    output logic             done,
    output logic             ovf,
    output logic [CNT_W-1:0] len
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    meter_st_t        st;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        done <= 1'b0;
        ovf  <= 1'b0;
        if (rst || !en) begin
            st  <= MT_SEEK_HIGH;
            cnt <= '0;
        end else begin
            case (st)
                MT_SEEK_HIGH: if (rx_s) st <= MT_SEEK_LOW;
                MT_SEEK_LOW: if (!rx_s) begin
                    st  <= MT_COUNT;
                    cnt <= CNT_W'(1);
                end
                MT_COUNT: begin
                    if (rx_s) begin
                        done <= 1'b1;
                        st   <= MT_HOLD;
                    end else if (cnt == CNT_MAX) begin
                        ovf <= 1'b1;
                        st  <= MT_HOLD;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    assign len = cnt;

    AST_OVF_AT_CEILING: assert property (@(posedge clk) disable iff (rst)
        ovf |-> (len == CNT_MAX)); // R5
    AST_DONE_NONZERO: assert property (@(posedge clk) disable iff (rst)
        done |-> (len != '0)); // R3
endmodule

// File: rtl/abl_uart_tx.sv
module abl_uart_tx import abl_pkg::*; #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [7:0]       data,
    input  logic [CNT_W-1:0] div,
    output logic             txd,
    output logic             done
);
    logic                  active;
    logic [CNT_W-1:0]      tick;
    logic [3:0]            bitn;
    logic [FRAME_BITS-1:0] frame;

    always_ff @(posedge clk) begin
        done <= 1'b0;
        if (rst) begin
            active <= 1'b0;
            txd    <= 1'b1;
            tick   <= '0;
            bitn   <= '0;
            frame  <= '1;
        end else if (!active) begin
            if (go) begin
                active <= 1'b1;
                frame  <= {1'b1, data, 1'b0};
                txd    <= 1'b0;
                tick   <= '0;
                bitn   <= '0;
            end
        end else if (tick == div - CNT_W'(1)) begin
            tick <= '0;
            if (bitn == 4'(FRAME_BITS - 1)) begin
                active <= 1'b0;
                done   <= 1'b1;
                txd    <= 1'b1;
            end else begin
                bitn <= bitn + 4'd1;
                txd  <= frame[bitn + 4'd1];
            end
        end else begin
            tick <= tick + CNT_W'(1);
        end
    end

    AST_TX_START_LOW: assert property (@(posedge clk) disable iff (rst)
        (go && !active) |=> !txd); // R6
endmodule

// File: rtl/abl_uart_rx.sv
module abl_uart_rx import abl_pkg::*; #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             rx_s,
    input  logic [CNT_W-1:0] div,
    output logic             valid,
    output rx_word_t         word
);
    rx_st_t           st;
    logic [CNT_W-1:0] tick;
    logic [2:0]       idx;
    logic [7:0]       sh;
    logic [CNT_W-1:0] half;

    assign half = div >> 1;

    always_ff @(posedge clk) begin
        valid <= 1'b0;
        if (rst || !en) begin
            st   <= RX_IDLE;
            tick <= '0;
            idx  <= '0;
            sh   <= '0;
            word <= '0;
        end else begin
            case (st)
                RX_IDLE: if (!rx_s) begin
                    st   <= RX_START;
                    tick <= '0;
                end
                RX_START: begin
                    if (tick == half - CNT_W'(1)) begin
                        tick <= '0;
                        idx  <= '0;
                        st   <= rx_s ? RX_IDLE : RX_DATA;
                    end else begin
                        tick <= tick + CNT_W'(1);
                    end
                end
                RX_DATA: begin
                    if (tick == div - CNT_W'(1)) begin
                        tick <= '0;
                        sh   <= {rx_s, sh[7:1]};
                        idx  <= idx + 3'd1;
                        if (idx == 3'd7) st <= RX_STOP;
                    end else begin
                        tick <= tick + CNT_W'(1);
                    end
                end
                RX_STOP: begin
                    if (tick == div - CNT_W'(1)) begin
                        tick          <= '0;
                        valid         <= 1'b1;
                        word.data     <= sh;
                        word.frame_ok <= rx_s;
                        st            <= RX_IDLE;
                    end else begin
                        tick <= tick + CNT_W'(1);
                    end
                end
                default: st <= RX_IDLE;
            endcase
        end
    end

    AST_RX_DIV_FLOOR: assert property (@(posedge clk) disable iff (rst)
        en |-> (div >= CNT_W'(MIN_DIV))); // R4
endmodule

// File: rtl/baud_lock_handshake.sv
module baud_lock_handshake import abl_pkg::*; #(
    parameter int CNT_W      = 16,
    parameter int SETTLE_CYC = 100
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rxd,
    output logic             txd,
    output logic [CNT_W-1:0] divisor,
    output logic             locked,
    output logic             failed
);
    localparam int SETTLE_W = $clog2(SETTLE_CYC + 1);

    phase_t            phase;
    logic [SETTLE_W-1:0] settle;
    logic              rx_s;
    logic              m_done, m_ovf;
    logic [CNT_W-1:0]  m_len;
    logic [CNT_W-1:0]  new_div;
    logic              tx_go, tx_done;
    logic              rx_valid;
    rx_word_t          rx_word;

    abl_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .d(rxd), .q(rx_s)
    );

    abl_low_meter #(.CNT_W(CNT_W)) u_meter (
        .clk(clk), .rst(rst), .en(phase == PH_MEASURE), .rx_s(rx_s),
        .done(m_done), .ovf(m_ovf), .len(m_len)
    );

    abl_uart_tx #(.CNT_W(CNT_W)) u_tx (
        .clk(clk), .rst(rst), .go(tx_go), .data(ACK_CODE), .div(divisor),
        .txd(txd), .done(tx_done)
    );

    abl_uart_rx #(.CNT_W(CNT_W)) u_rx (
        .clk(clk), .rst(rst), .en(phase == PH_LISTEN), .rx_s(rx_s),
        .div(divisor), .valid(rx_valid), .word(rx_word)
    );

    assign new_div = CNT_W'(div_nearest(32'(m_len)));

    always_ff @(posedge clk) begin
        tx_go <= 1'b0;
        if (rst) begin
            phase   <= PH_WAIT;
            settle  <= '0;
            divisor <= '0;
        end else begin
            case (phase)
                PH_WAIT: begin
                    if (settle == SETTLE_W'(SETTLE_CYC - 1)) phase <= PH_MEASURE;
                    else settle <= settle + SETTLE_W'(1);
                end
                PH_MEASURE: begin
                    if (m_ovf) begin
                        phase <= PH_FAILED;
                    end else if (m_done) begin
                        divisor <= new_div;
                        if (new_div < CNT_W'(MIN_DIV)) begin
                            phase <= PH_FAILED;
                        end else begin
                            phase <= PH_ACK;
                            tx_go <= 1'b1;
                        end
                    end
                end
                PH_ACK: if (tx_done) phase <= PH_LISTEN;
                PH_LISTEN: if (rx_valid) begin
                    phase <= (rx_word.frame_ok && rx_word.data == CONFIRM_CODE)
                             ? PH_LOCKED : PH_FAILED;
                end
                default: ;
            endcase
        end
    end

    assign locked = (phase == PH_LOCKED);
    assign failed = (phase == PH_FAILED);

    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (rst)
        locked |=> locked); // R10
    AST_FAIL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        failed |=> failed); // R10
    AST_DIV_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (locked || failed) |=> $stable(divisor)); // R10
    AST_LOCK_DIV_MIN: assert property (@(posedge clk) disable iff (rst)
        locked |-> (divisor >= CNT_W'(MIN_DIV))); // R4
    AST_TX_QUIET: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_ACK) |-> txd); // R6
    AST_NO_EARLY_DIV: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WAIT) |-> (divisor == '0)); // R2
endmodule

// File: tb/sim_baud_lock_handshake.sv
module sim_baud_lock_handshake;
    localparam int CW    = 12;
    localparam int CMAX  = (1 << CW) - 1;
    localparam int NEVER = 32'h3fffffff;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rxd = 1'b1;
    logic          rst_q = 1'b1;
    logic          txd, locked, failed;
    logic [CW-1:0] divisor;

    int cyc = 0;
    int checks = 0;
    int errors = 0;

    // reference schedule, in absolute clock-edge numbers
    int t_div = NEVER, v_div = 0, t_tx0 = NEVER, tx_len = 0;
    int t_lock = NEVER, t_fail = NEVER;
    string fail_tag = "R10";

    baud_lock_handshake #(.CNT_W(CW), .SETTLE_CYC(100)) u0 (
        .clk(clk), .rst(rst), .rxd(rxd), .txd(txd),
        .divisor(divisor), .locked(locked), .failed(failed)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc   <= cyc + 1;
        rst_q <= rst;
    end

    task automatic chk(input string tag, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s at cycle %0d: got %0d expected %0d", tag, what, cyc, got, exp);
        end
    endtask

    // per-clock comparison against the behavioural model
    always @(negedge clk) begin
        int e_txd, e_div, e_lock, e_fail;
        if (cyc >= 1) begin
            if (rst_q) begin
                chk("R1", "txd", int'(txd), 1);
                chk("R1", "divisor", int'(divisor), 0);
                chk("R1", "locked", int'(locked), 0);
                chk("R1", "failed", int'(failed), 0);
            end else begin
                e_div  = (cyc >= t_div) ? v_div : 0;
                e_txd  = (cyc >= t_tx0 && cyc < t_tx0 + tx_len) ? 0 : 1;
                e_lock = (cyc >= t_lock) ? 1 : 0;
                e_fail = (cyc >= t_fail) ? 1 : 0;
                chk("R6", "txd", int'(txd), e_txd);
                chk("R3", "divisor", int'(divisor), e_div);
                chk("R7", "locked", int'(locked), e_lock);
                chk(fail_tag, "failed", int'(failed), e_fail);
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        rxd = 1'b1;
        @(posedge clk);
        #1;
        t_div = NEVER; v_div = 0; t_tx0 = NEVER; tx_len = 0;
        t_lock = NEVER; t_fail = NEVER; fail_tag = "R10";
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // host sends a low stretch of exactly len clocks, then idles high
    task automatic send_low(input int len);
        int c0, d;
        @(negedge clk);
        c0 = cyc + 1;
        if (len > CMAX) begin
            t_fail = c0 + CMAX + 3;
        end else begin
            d = (len + 4) / 9;
            t_div = c0 + len + 3;
            v_div = d;
            if (d < 2) begin
                t_fail = c0 + len + 3;
            end else begin
                t_tx0  = c0 + len + 4;
                tx_len = 9 * d;
            end
        end
        rxd = 1'b0;
        repeat (len - 1) @(negedge clk);
        @(negedge clk);
        rxd = 1'b1;
    endtask

    // outcome: 0 none, 1 lock, 2 fail
    task automatic send_byte(input int d, input logic [7:0] b, input logic stop, input int outcome);
        int q0;
        @(negedge clk);
        q0 = cyc + 1;
        if (outcome == 1) t_lock = q0 + d / 2 + 9 * d + 3;
        if (outcome == 2) t_fail = q0 + d / 2 + 9 * d + 3;
        rxd = 1'b0;
        repeat (d - 1) @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            rxd = b[k];
            repeat (d - 1) @(negedge clk);
        end
        @(negedge clk);
        rxd = stop;
        repeat (d - 1) @(negedge clk);
        @(negedge clk);
        rxd = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R7 watchdog: got cycle %0d expected completion earlier", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset values
        repeat (4) @(negedge clk);
        chk("R1", "txd in reset", int'(txd), 1);
        chk("R1", "locked in reset", int'(locked), 0);
        do_reset();

        // R2: pulse inside the settle window is ignored; R3/R6/R7 nominal
        idle(20);
        rxd = 1'b0;
        idle(40);
        rxd = 1'b1;
        idle(60);
        chk("R2", "divisor after early pulse", int'(divisor), 0);
        send_low(180);
        idle(10 * 20 + 20);
        chk("R2", "divisor from post-window pulse", int'(divisor), 20);
        send_byte(20, 8'h55, 1'b1, 1);
        idle(30);
        chk("R7", "locked after 0x55", int'(locked), 1);
        send_byte(20, 8'h00, 1'b1, 0);   // R10: ignored after lock
        idle(20);
        chk("R10", "divisor after lock traffic", int'(divisor), 20);
        chk("R10", "locked kept", int'(locked), 1);

        // R3 rounding up, R8 wrong byte, R10 ignored after fail
        do_reset();
        idle(110);
        send_low(185);
        idle(10 * 21 + 20);
        chk("R3", "round up 185", int'(divisor), 21);
        fail_tag = "R8";
        send_byte(21, 8'h33, 1'b1, 2);
        idle(20);
        chk("R8", "failed on wrong byte", int'(failed), 1);
        fail_tag = "R10";
        send_byte(21, 8'h55, 1'b1, 0);
        idle(20);
        chk("R10", "locked stays low after fail", int'(locked), 0);
        chk("R10", "failed held", int'(failed), 1);

        // R3 rounding down, R9 bad stop bit
        do_reset();
        idle(110);
        send_low(184);
        idle(10 * 20 + 20);
        chk("R3", "round down 184", int'(divisor), 20);
        fail_tag = "R9";
        send_byte(20, 8'h55, 1'b0, 2);
        idle(20);
        chk("R9", "failed on framing", int'(failed), 1);

        // R4: divisor below two
        do_reset();
        idle(110);
        fail_tag = "R4";
        send_low(13);
        idle(20);
        chk("R4", "divisor 1 shown", int'(divisor), 1);
        chk("R4", "failed on tiny divisor", int'(failed), 1);
        chk("R4", "no acknowledge", int'(txd), 1);

        // R4/R7 boundary: divisor of exactly two locks
        do_reset();
        idle(110);
        send_low(14);
        idle(10 * 2 + 20);
        chk("R4", "divisor 2", int'(divisor), 2);
        send_byte(2, 8'h55, 1'b1, 1);
        idle(10);
        chk("R7", "locked at divisor 2", int'(locked), 1);

        // R5: longest countable pulse
        do_reset();
        idle(110);
        send_low(CMAX);
        idle(10 * 455 + 20);
        chk("R5", "divisor at ceiling", int'(divisor), 455);
        chk("R5", "no failure at ceiling", int'(failed), 0);

        // R5: one cycle longer overflows
        do_reset();
        idle(110);
        fail_tag = "R5";
        send_low(CMAX + 1);
        idle(20);
        chk("R5", "failed on overflow", int'(failed), 1);
        chk("R5", "divisor untouched", int'(divisor), 0);

        // R2: line already low when the window ends is skipped
        do_reset();
        fail_tag = "R10";
        rxd = 1'b0;
        idle(150);
        rxd = 1'b1;
        idle(20);
        chk("R2", "no measure of held-low line", int'(divisor), 0);
        send_low(90);
        idle(10 * 10 + 20);
        chk("R2", "measured next edge", int'(divisor), 10);

        idle(5);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule